// File: doc/BRIEF.md
# Stop-Mode Wake Sequencer

This block sequences how a small processor subsystem enters and leaves a low-power state in which every clock is stopped. A stop request halts the oscillator, the peripheral clock group and the CPU and bus clocks. It also loads the watchdog counter with an all-ones value and records the processor priority level in force at that moment. Any enabled interrupt whose priority level is above that recorded level restarts the oscillator and the peripheral clocks at once. The CPU and bus clocks stay off while the oscillator settles.

The watchdog down-counter times the settling period. While waking it always counts on the fast prescaler tap. When its most significant bit falls to zero, the CPU and bus clock enables come on and a one-cycle wake-done pulse is issued. From then on the counter uses the tap chosen by the frequency-select input. Requests that arrive before or during settling are held pending. Once the CPU runs, they are accepted one per cycle, highest level first, and the accepted index is presented. The oscillator, the dividers and the core are modelled as enables and tick strobes.

Top module: `stopwake_seq`

## Requirements
- R1: After reset, all clock enables are 1, the watchdog count is all ones, and `wake_done` and `ack_valid` are 0.
- R2: A stop request taken in run mode clears every clock enable and `wdt_tick` from the next edge. The same edge loads the watchdog count with all ones.
- R3: While stopped, a request on a line whose level exceeds the stop-time priority level sets `osc_en` and `per_clk_en` after the edge that samples it. `cpu_clk_en` and `bus_clk_en` stay 0 at that point.
- R4: During settling the counter decrements every FAST_DIV cycles whatever `wdt_fsel` holds. The CPU and bus enables rise at the edge where the count's MSB goes to 0, which is 2^(CNT_W-1)*FAST_DIV cycles after the waking edge. `wake_done` is high for exactly that first cycle.
- R5: In run mode `wdt_tick` pulses every FAST_DIV cycles when `wdt_fsel` is 0 and every SLOW_DIV cycles when it is 1.
- R6: While stopped, a request whose level is less than or equal to the stop-time priority level does not wake the block.
- R7: A request on a line whose level is 0 is neither latched nor accepted, and it never wakes the block.
- R8: In run mode one pending request is accepted per cycle, and only if its level exceeds the current `ipl`. The highest level goes first, and the lower index wins ties. After a wake, the first acceptance appears in the cycle after `wake_done`.
- R9: A stop request is ignored while an acceptable request is pending, and the block stays in run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | Request to enter the stopped state |
| irq_req | input | N_IRQ | Interrupt request strobes, one per line |
| irq_lvl | input | N_IRQ*LVL_W | Priority level per line, line i at bits i*LVL_W upward; 0 means disabled |
| ipl | input | LVL_W | Current processor priority level |
| wdt_fsel | input | 1 | Watchdog tap select: 0 fast, 1 slow |
| osc_en | output | 1 | Oscillator running |
| per_clk_en | output | 1 | Peripheral and prescaler clock group enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| bus_clk_en | output | 1 | Bus-interface clock enable |
| wdt_tick | output | 1 | Watchdog count strobe |
| wdt_cnt | output | CNT_W | Watchdog counter value |
| wake_done | output | 1 | One-cycle pulse when the CPU clocks restart |
| ack_valid | output | 1 | An interrupt is accepted this cycle |
| ack_id | output | IDW | Index of the accepted interrupt |

## Verification
Every result is registered. Clock enables and `wake_done` change on the edge that samples the stimulus. An acceptance shows up one edge after its request is latched, so it appears two edges after the request strobe. The CPU enables come up exactly 2^(CNT_W-1)*FAST_DIV edges after the waking edge. The bench drives and samples on falling edges and counts falling edges from the waking stimulus to the rise of `cpu_clk_en`. It measures tick spacing the same way. A scoreboard queue holds the expected acceptance order and is drained by a monitor that compares each `ack_id` in the cycle where `ack_valid` is high.

// File: rtl/stopwake_pkg.sv
package stopwake_pkg;

    typedef enum logic [1:0] {
        SW_RUN    = 2'd0,
        SW_STOP   = 2'd1,
        SW_SETTLE = 2'd2
    } sw_state_e;

endpackage

// File: rtl/swk_prio_pick.sv
module swk_prio_pick #(
    parameter int N_IRQ = 4,
    parameter int LVL_W = 3,
    localparam int IDW  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic [N_IRQ-1:0]       cand,
    input  logic [N_IRQ*LVL_W-1:0] lvl,
    input  logic [LVL_W-1:0]       floor_lvl,
    output logic                   hit,
    output logic [IDW-1:0]         idx
);

    logic [LVL_W-1:0] best;

    // Strict compare keeps the lower index on equal levels; floor >= 0 excludes level 0.
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        best = '0;
        for (int i = 0; i < N_IRQ; i++) begin
            if (cand[i] && (lvl[i*LVL_W +: LVL_W] > floor_lvl) &&
                (!hit || (lvl[i*LVL_W +: LVL_W] > best))) begin
                hit  = 1'b1;
                best = lvl[i*LVL_W +: LVL_W];
                idx  = IDW'(i);
            end
        end
    end

endmodule

// File: rtl/swk_settle_timer.sv
module swk_settle_timer #(
    parameter int CNT_W    = 8,
    parameter int FAST_DIV = 4,
    parameter int SLOW_DIV = 16,
    localparam int PW      = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             count_en,
    input  logic             use_slow,
    output logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             msb_last
);

    typedef struct packed {
        logic [PW-1:0]    presc;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    localparam logic [CNT_W-1:0] MSB_EDGE = {1'b1, {(CNT_W-1){1'b0}}};

    tmr_t          t_d, t_q;
    logic [PW-1:0] lim_m1;

    always_comb begin
        lim_m1   = use_slow ? PW'(SLOW_DIV - 1) : PW'(FAST_DIV - 1);
        tick     = count_en && (t_q.presc >= lim_m1);
        msb_last = tick && (t_q.cnt == MSB_EDGE);
        t_d      = t_q;
        if (load) begin
            t_d.presc = '0;
            t_d.cnt   = '1;
        end else if (count_en) begin
            if (tick) begin
                t_d.presc = '0;
                t_d.cnt   = t_q.cnt - 1'b1;
            end else begin
                t_d.presc = t_q.presc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.presc <= '0;
            t_q.cnt   <= '1;
        end else begin
            t_q <= t_d;
        end
    end

    assign cnt = t_q.cnt;

endmodule

// File: rtl/stopwake_seq.sv
module stopwake_seq
    import stopwake_pkg::*;
#(
    parameter int N_IRQ    = 4,
    parameter int LVL_W    = 3,
    parameter int CNT_W    = 8,
    parameter int FAST_DIV = 4,
    parameter int SLOW_DIV = 16,
    localparam int IDW     = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   stop_req,
    input  logic [N_IRQ-1:0]       irq_req,
    input  logic [N_IRQ*LVL_W-1:0] irq_lvl,
    input  logic [LVL_W-1:0]       ipl,
    input  logic                   wdt_fsel,
    output logic                   osc_en,
    output logic                   per_clk_en,
    output logic                   cpu_clk_en,
    output logic                   bus_clk_en,
    output logic                   wdt_tick,
    output logic [CNT_W-1:0]       wdt_cnt,
    output logic                   wake_done,
    output logic                   ack_valid,
    output logic [IDW-1:0]         ack_id
);

    typedef struct packed {
        sw_state_e        state;
        logic [N_IRQ-1:0] pend;
        logic [LVL_W-1:0] ipl_stop;
        logic             wake_done;
        logic             ack_valid;
        logic [IDW-1:0]   ack_id;
    } seq_t;

    seq_t             s_d, s_q;
    logic [N_IRQ-1:0] lvl_nz;
    logic [N_IRQ-1:0] new_req;
    logic [N_IRQ-1:0] wake_cand;
    logic             wake_hit;
    logic [IDW-1:0]   wake_idx;
    logic             acc_hit;
    logic [IDW-1:0]   acc_idx;
    logic             tmr_load;
    logic             tmr_run;
    logic             tmr_slow;
    logic             tmr_last;

    always_comb begin
        for (int i = 0; i < N_IRQ; i++) begin
            lvl_nz[i] = |irq_lvl[i*LVL_W +: LVL_W];
        end
        new_req   = irq_req & lvl_nz;
        wake_cand = s_q.pend | new_req;
    end

    swk_prio_pick #(.N_IRQ(N_IRQ), .LVL_W(LVL_W)) u_wake_pick (
        .cand      (wake_cand),
        .lvl       (irq_lvl),
        .floor_lvl (s_q.ipl_stop),
        .hit       (wake_hit),
        .idx       (wake_idx)
    );

    swk_prio_pick #(.N_IRQ(N_IRQ), .LVL_W(LVL_W)) u_acc_pick (
        .cand      (s_q.pend),
        .lvl       (irq_lvl),
        .floor_lvl (ipl),
        .hit       (acc_hit),
        .idx       (acc_idx)
    );

    swk_settle_timer #(
        .CNT_W    (CNT_W),
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .count_en (tmr_run),
        .use_slow (tmr_slow),
        .tick     (wdt_tick),
        .cnt      (wdt_cnt),
        .msb_last (tmr_last)
    );

    assign tmr_run  = (s_q.state != SW_STOP);
    assign tmr_slow = wdt_fsel && (s_q.state == SW_RUN);

    always_comb begin
        s_d           = s_q;
        s_d.pend      = s_q.pend | new_req;
        s_d.wake_done = 1'b0;
        s_d.ack_valid = 1'b0;
        tmr_load      = 1'b0;
        unique case (s_q.state)
            SW_RUN: begin
                if (acc_hit) begin
                    s_d.ack_valid     = 1'b1;
                    s_d.ack_id        = acc_idx;
                    s_d.pend[acc_idx] = 1'b0;
                end else if (stop_req) begin
                    s_d.state    = SW_STOP;
                    s_d.ipl_stop = ipl;
                    tmr_load     = 1'b1;
                end
            end
            SW_STOP: begin
                if (wake_hit) begin
                    s_d.state = SW_SETTLE;
                end
            end
            SW_SETTLE: begin
                if (tmr_last) begin
                    s_d.state     = SW_RUN;
                    s_d.wake_done = 1'b1;
                end
            end
            default: s_d.state = SW_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state     <= SW_RUN;
            s_q.pend      <= '0;
            s_q.ipl_stop  <= '0;
            s_q.wake_done <= 1'b0;
            s_q.ack_valid <= 1'b0;
            s_q.ack_id    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign osc_en     = (s_q.state != SW_STOP);
    assign per_clk_en = (s_q.state != SW_STOP);
    assign cpu_clk_en = (s_q.state == SW_RUN);
    assign bus_clk_en = (s_q.state == SW_RUN);
    assign wake_done  = s_q.wake_done;
    assign ack_valid  = s_q.ack_valid;
    assign ack_id     = s_q.ack_id;

    logic unused_wake_idx;
    assign unused_wake_idx = ^wake_idx;

endmodule

// File: rtl/stopwake_seq_chk.sv
module stopwake_seq_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             osc_en,
    input logic             per_clk_en,
    input logic             cpu_clk_en,
    input logic             bus_clk_en,
    input logic             wdt_tick,
    input logic [CNT_W-1:0] wdt_cnt,
    input logic             wake_done,
    input logic             ack_valid
);

    a_r2_all_off_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (!per_clk_en && !cpu_clk_en && !bus_clk_en && !wdt_tick));

    a_r2_preset_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en) |-> (wdt_cnt == {CNT_W{1'b1}}));

    a_r3_wake_starts_with_cpu_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |-> (per_clk_en && !cpu_clk_en && !bus_clk_en));

    a_r4_cpu_start_on_msb_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_en) |-> (!wdt_cnt[CNT_W-1] && wake_done));

    a_r4_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |=> !wake_done);

    a_r8_ack_only_when_running: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> ($past(cpu_clk_en) && cpu_clk_en));

endmodule

bind stopwake_seq stopwake_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_en     (osc_en),
    .per_clk_en (per_clk_en),
    .cpu_clk_en (cpu_clk_en),
    .bus_clk_en (bus_clk_en),
    .wdt_tick   (wdt_tick),
    .wdt_cnt    (wdt_cnt),
    .wake_done  (wake_done),
    .ack_valid  (ack_valid)
);

// File: tb/stopwake_seq_tb.sv
module stopwake_seq_tb;

    localparam int N_IRQ      = 4;
    localparam int LVL_W      = 3;
    localparam int CNT_W      = 8;
    localparam int FAST_DIV   = 4;
    localparam int SLOW_DIV   = 16;
    localparam int IDW        = 2;
    localparam int SETTLE_CYC = (1 << (CNT_W - 1)) * FAST_DIV;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   stop_req = 1'b0;
    logic [N_IRQ-1:0]       irq_req = '0;
    logic [N_IRQ*LVL_W-1:0] irq_lvl = '0;
    logic [LVL_W-1:0]       ipl = '0;
    logic                   wdt_fsel = 1'b0;
    logic                   osc_en, per_clk_en, cpu_clk_en, bus_clk_en;
    logic                   wdt_tick, wake_done, ack_valid;
    logic [CNT_W-1:0]       wdt_cnt;
    logic [IDW-1:0]         ack_id;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_q[$];
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    stopwake_seq #(
        .N_IRQ(N_IRQ), .LVL_W(LVL_W), .CNT_W(CNT_W),
        .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .irq_req(irq_req),
        .irq_lvl(irq_lvl), .ipl(ipl), .wdt_fsel(wdt_fsel),
        .osc_en(osc_en), .per_clk_en(per_clk_en), .cpu_clk_en(cpu_clk_en),
        .bus_clk_en(bus_clk_en), .wdt_tick(wdt_tick), .wdt_cnt(wdt_cnt),
        .wake_done(wake_done), .ack_valid(ack_valid), .ack_id(ack_id)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_lvl(input int i, input int l);
        irq_lvl[i*LVL_W +: LVL_W] = LVL_W'(l);
    endtask

    task automatic pulse_irq(input int i);
        irq_req[i] = 1'b1;
        step();
        irq_req = '0;
    endtask

    task automatic enter_stop();
        stop_req = 1'b1;
        step();
        stop_req = 1'b0;
    endtask

    task automatic expect_ack(input int id);
        exp_q.push_back(id);
    endtask

    // Spacing between two consecutive ticks, after one gap is discarded.
    task automatic run_gap(output int gap);
        int c;
        c = 0;
        while (!wdt_tick && c < 100) begin step(); c++; end
        for (int k = 0; k < 2; k++) begin
            c = 0;
            do begin step(); c++; end while (!wdt_tick && c < 100);
        end
        gap = c;
    endtask

    // Called at the falling edge right after the waking edge.
    task automatic settle_phase(input logic [N_IRQ-1:0] mid_req, input string tag);
        int c, last, bad;
        c = 0; last = -1; bad = 0;
        while (!cpu_clk_en && c < 4 * SETTLE_CYC) begin
            irq_req = (c == 10) ? mid_req : '0;
            if (wdt_tick) begin
                if (last >= 0 && (c - last) != FAST_DIV) bad++;
                last = c;
            end
            step();
            c++;
        end
        irq_req = '0;
        chk({"R4 settle length ", tag}, c, SETTLE_CYC);
        chk({"R4 fast tick spacing in settle ", tag}, bad, 0);
        chk({"R4 wake_done pulse ", tag}, int'(wake_done), 1);
        chk({"R4 bus enable with cpu ", tag}, int'(bus_clk_en), 1);
        step();
        chk({"R4 wake_done one cycle ", tag}, int'(wake_done), 0);
        chk({"R8 first ack after wake_done ", tag}, int'(ack_valid), 1);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && ack_valid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R8 unexpected ack actual=%0d expected=none", ack_id);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (int'(ack_id) != e) begin
                    n_fail++;
                    $display("FAIL R8 ack order actual=%0d expected=%0d", ack_id, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int g;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 osc_en", int'(osc_en), 1);
        chk("R1 cpu_clk_en", int'(cpu_clk_en), 1);
        chk("R1 wdt_cnt", int'(wdt_cnt), (1 << CNT_W) - 1);
        chk("R1 ack_valid", int'(ack_valid), 0);
        chk("R1 wake_done", int'(wake_done), 0);

        // R5 run-mode tap selection
        wdt_fsel = 1'b0;
        run_gap(g);
        chk("R5 fast tap spacing", g, FAST_DIV);
        wdt_fsel = 1'b1;
        run_gap(g);
        chk("R5 slow tap spacing", g, SLOW_DIV);

        // Scenario A: wake with pending ordering, fsel=1 during settle
        set_lvl(0, 2); set_lvl(1, 5); set_lvl(2, 3); set_lvl(3, 5);
        ipl = 3'd2;
        enter_stop();
        chk("R2 osc off", int'(osc_en), 0);
        chk("R2 per off", int'(per_clk_en), 0);
        chk("R2 cpu off", int'(cpu_clk_en), 0);
        chk("R2 counter preset", int'(wdt_cnt), (1 << CNT_W) - 1);
        repeat (4) step();
        chk("R2 no tick while stopped", int'(wdt_tick), 0);

        pulse_irq(0);                      // level 2 equals stop-time level
        repeat (5) step();
        chk("R6 equal level no wake", int'(osc_en), 0);

        set_lvl(2, 0);
        pulse_irq(2);                      // disabled line
        set_lvl(2, 3);
        repeat (5) step();
        chk("R7 level 0 not latched", int'(osc_en), 0);

        expect_ack(1); expect_ack(3); expect_ack(2);
        pulse_irq(2);                      // waking edge
        chk("R3 osc on", int'(osc_en), 1);
        chk("R3 per on", int'(per_clk_en), 1);
        chk("R3 cpu still off", int'(cpu_clk_en), 0);
        settle_phase(4'b1010, "A");
        repeat (8) step();
        chk("R8 queue drained A (irq0 below ipl)", exp_q.size(), 0);

        // Scenario B: stop ignored while acceptable request pending
        expect_ack(1);
        irq_req[1] = 1'b1;
        step();
        irq_req = '0;
        stop_req = 1'b1;
        step();
        stop_req = 1'b0;
        chk("R9 osc stays on", int'(osc_en), 1);
        step();
        chk("R9 cpu stays on", int'(cpu_clk_en), 1);
        chk("R9 ack taken", exp_q.size(), 0);

        // Scenario C: fsel=0 settle, then threshold release
        wdt_fsel = 1'b0;
        enter_stop();
        chk("R2 stop taken C", int'(osc_en), 0);
        expect_ack(3);
        pulse_irq(3);
        chk("R3 osc on C", int'(osc_en), 1);
        settle_phase(4'b0000, "C");
        repeat (5) step();
        chk("R8 irq0 held at ipl 2", exp_q.size(), 0);
        expect_ack(0);
        ipl = 3'd1;
        repeat (5) step();
        chk("R8 irq0 accepted after ipl drop", exp_q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule